// File: doc/BRIEF.md
# Fuse Shadow Register Bank

This block keeps a register copy of every word of a one-time-programmable fuse array, so that bus reads of fuse values are answered from flops instead of from the slow array. After reset, after a software request, or after the external programming sequencer signals that a fuse word has been burned, the block walks the array from word 0 upward and copies each fuse word into its shadow. Each fuse word takes a fixed number of clock cycles to read.

Software reaches the shadows through a simple single-cycle register port. Per-word lock vectors decide which shadows may be read and which may be overwritten. Any access that breaks a lock, and any shadow write that arrives while a copy is running, raises one sticky error flag. That flag blocks further shadow accesses and copy requests until software clears it.

Top module: `fuse_shadow_bank`

## Requirements
- R1: Shadow word N (N below NUM_WORDS, which is 64 or 128) sits at bus address 0x400 + 16·N. A read strobe loads that word into `bus_rdata` at the next clock edge, and `bus_rdata` holds its value until the next read. A permitted write replaces the word.
- R2: Reading a shadow word whose `rd_lock` bit is 1 returns 32'hBADABADA and sets the error flag.
- R3: A shadow write that arrives while a copy is running sets the error flag and leaves the shadow unchanged.
- R4: A shadow write to a word whose `wr_lock` bit is 1 sets the error flag and leaves the shadow unchanged.
- R5: Writing a 1 in bit 10 to address 0x004 while idle and error-free starts a copy. `busy_o` stays high until the last word has been stored, then falls.
- R6: While the error flag is set, shadow reads return 32'hBADABADA, shadow writes are dropped, and copy requests are ignored. Writing a 1 in bit 9 to address 0x008 clears the flag.
- R7: A copy holds `fuse_rd` high and presents `fuse_addr` = 0, 1, 2, … in ascending order. Each address is held for STROBE_CYC cycles, and `fuse_rdata` is stored at the end of that window. A complete copy takes NUM_WORDS·STROBE_CYC cycles.
- R8: A read of any other address returns zero and leaves the error flag alone. This covers addresses between stride slots, addresses past the last word, and addresses below 0x400 that are not status addresses. Writes to such addresses change nothing.
- R9: Leaving reset starts a copy automatically, with `busy_o` high and the error flag clear.
- R10: A one-cycle `prog_done` pulse while idle and error-free starts a copy.
- R11: A read of address 0x000, 0x004 or 0x008 returns the status word. In that word, bit 8 is busy, bit 9 is the error flag, bit 10 is the copy-running flag, and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rd_lock | input | NUM_WORDS | Per-word read lock |
| wr_lock | input | NUM_WORDS | Per-word write lock |
| prog_done | input | 1 | Pulse from the programming sequencer at the end of a fuse burn |
| fuse_rd | output | 1 | Fuse array read enable, high during a copy |
| fuse_addr | output | log2(NUM_WORDS) | Fuse word being read |
| fuse_rdata | input | 32 | Fuse word at `fuse_addr` |
| busy_o | output | 1 | Copy in progress |
| err_o | output | 1 | Sticky error flag |

## Verification
The assertions take for granted that a read strobe and a write strobe never arrive in the same cycle, so that an error clear and a new violation cannot collide. They also assume that `fuse_rdata` follows `fuse_addr` without delay. The stimulus drives only one access at a time and models the fuse array as a combinational function of the address plus a salt. The salt is changed only while the block is idle, which stands in for a fuse burn between copies.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  localparam int          WORD_W      = 32;
  localparam logic [31:0] POISON      = 32'hBADA_BADA;
  localparam int          BUSY_BIT    = 8;
  localparam int          ERR_BIT     = 9;
  localparam int          RLD_BIT     = 10;
  localparam int          SHADOW_BASE = 'h400;
  localparam int          STAT_OFF    = 'h000;
  localparam int          SET_OFF     = 'h004;
  localparam int          CLR_OFF     = 'h008;
endpackage

// File: rtl/fsb_decode.sv
module fsb_decode
  import fsb_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_WORDS = 128,
  parameter int IDX_W     = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_sh,
  output logic [IDX_W-1:0]  idx,
  output logic              hit_stat,
  output logic              hit_set,
  output logic              hit_clr
);
  localparam int SLOT_W = ADDR_W - 4;

  logic [ADDR_W-1:0] off;
  logic [SLOT_W-1:0] slot;

  always_comb begin
    off      = addr - ADDR_W'(SHADOW_BASE);
    slot     = off[ADDR_W-1:4];
    hit_sh   = (addr >= ADDR_W'(SHADOW_BASE)) && (off[3:0] == 4'h0) &&
               (int'(slot) < NUM_WORDS);
    idx      = slot[IDX_W-1:0];
    hit_set  = (addr == ADDR_W'(SET_OFF));
    hit_clr  = (addr == ADDR_W'(CLR_OFF));
    hit_stat = (addr == ADDR_W'(STAT_OFF)) || hit_set || hit_clr;
  end
endmodule

// File: rtl/fsb_reload.sv
module fsb_reload #(
  parameter int NUM_WORDS  = 128,
  parameter int STROBE_CYC = 4,
  parameter int IDX_W      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic             capture
);
  localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;

  logic             active_q, active_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  always_comb begin
    capture  = active_q && (cnt_q == CNT_W'(STROBE_CYC - 1));
    last     = (idx_q == IDX_W'(NUM_WORDS - 1));
    active_d = active_q;
    idx_d    = idx_q;
    cnt_d    = cnt_q;
    if (active_q) begin
      if (capture) begin
        cnt_d = '0;
        if (last) begin
          active_d = 1'b0;
          idx_d    = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (start) begin
      active_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      cnt_q    <= cnt_d;
    end
  end

  assign active = active_q;
  assign idx    = idx_q;
endmodule

// File: rtl/fsb_store.sv
module fsb_store
  import fsb_pkg::*;
#(
  parameter int NUM_WORDS = 128,
  parameter int IDX_W     = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [NUM_WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/fuse_shadow_bank.sv
module fuse_shadow_bank
  import fsb_pkg::*;
#(
  parameter  int NUM_WORDS  = 128,
  parameter  int STROBE_CYC = 4,
  parameter  int ADDR_W     = 12,
  localparam int IDX_W      = $clog2(NUM_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  input  logic [NUM_WORDS-1:0] rd_lock,
  input  logic [NUM_WORDS-1:0] wr_lock,
  input  logic                 prog_done,
  output logic                 fuse_rd,
  output logic [IDX_W-1:0]     fuse_addr,
  input  logic [WORD_W-1:0]    fuse_rdata,
  output logic                 busy_o,
  output logic                 err_o
);
  logic             hit_sh, hit_stat, hit_set, hit_clr;
  logic [IDX_W-1:0] acc_idx, ld_idx, st_widx;
  logic             busy, capture, start, st_we;
  logic [WORD_W-1:0] st_wdata, st_rdata, status;
  logic             err_q, err_d;
  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic             sh_rd, sh_wr, rd_bad, wr_bad, wr_ok, clr_req, rld_req;

  fsb_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_dec (
    .addr(bus_addr), .hit_sh(hit_sh), .idx(acc_idx),
    .hit_stat(hit_stat), .hit_set(hit_set), .hit_clr(hit_clr)
  );

  fsb_reload #(.NUM_WORDS(NUM_WORDS), .STROBE_CYC(STROBE_CYC), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .active(busy), .idx(ld_idx), .capture(capture)
  );

  fsb_store #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .we(st_we), .widx(st_widx), .wdata(st_wdata),
    .ridx(acc_idx), .rdata(st_rdata)
  );

  always_comb begin
    sh_rd   = bus_rd & hit_sh;
    sh_wr   = bus_wr & hit_sh;
    rd_bad  = sh_rd & ~err_q & rd_lock[acc_idx];
    wr_bad  = sh_wr & ~err_q & (busy | wr_lock[acc_idx]);
    wr_ok   = sh_wr & ~err_q & ~busy & ~wr_lock[acc_idx];
    clr_req = bus_wr & hit_clr & bus_wdata[ERR_BIT];
    rld_req = (bus_wr & hit_set & bus_wdata[RLD_BIT]) | prog_done;
    start   = rld_req & ~busy & ~err_q;

    err_d = err_q;
    if (clr_req)         err_d = 1'b0;
    if (rd_bad | wr_bad) err_d = 1'b1;

    st_we    = capture | wr_ok;
    st_widx  = capture ? ld_idx : acc_idx;
    st_wdata = capture ? fuse_rdata : bus_wdata;

    status          = '0;
    status[BUSY_BIT] = busy;
    status[ERR_BIT]  = err_q;
    status[RLD_BIT]  = busy;

    rdata_d = rdata_q;
    if (bus_rd) begin
      if (hit_stat)    rdata_d = status;
      else if (hit_sh) rdata_d = (err_q | rd_lock[acc_idx]) ? POISON : st_rdata;
      else             rdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign busy_o    = busy;
  assign err_o     = err_q;
  assign fuse_rd   = busy;
  assign fuse_addr = ld_idx;
endmodule

// File: rtl/fsb_checker.sv
module fsb_checker
  import fsb_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_WORDS = 128,
  parameter int IDX_W     = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_rd,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 clr_bit,
  input logic [WORD_W-1:0]    bus_rdata,
  input logic [NUM_WORDS-1:0] rd_lock,
  input logic [NUM_WORDS-1:0] wr_lock,
  input logic                 fuse_rd,
  input logic [IDX_W-1:0]     fuse_addr,
  input logic                 busy_o,
  input logic                 err_o
);
  logic [ADDR_W-1:0] c_off;
  logic              c_sh, c_ctl;
  logic [IDX_W-1:0]  c_idx;

  always_comb begin
    c_off = bus_addr - ADDR_W'(SHADOW_BASE);
    c_idx = c_off[4 +: IDX_W];
    c_sh  = (bus_addr >= ADDR_W'(SHADOW_BASE)) && (c_off[3:0] == 4'h0) &&
            (int'(c_off[ADDR_W-1:4]) < NUM_WORDS);
    c_ctl = (bus_addr == ADDR_W'(STAT_OFF)) || (bus_addr == ADDR_W'(SET_OFF)) ||
            (bus_addr == ADDR_W'(CLR_OFF));
  end

  a_r2_locked_poison: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && c_sh && rd_lock[c_idx]) |=> (bus_rdata == POISON && err_o));

  a_r3_busy_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && c_sh && busy_o) |=> err_o);

  a_r4_locked_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && c_sh && wr_lock[c_idx]) |=> err_o);

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !(bus_wr && bus_addr == ADDR_W'(CLR_OFF) && clr_bit)) |=> err_o);

  a_r6_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && err_o) |=> !busy_o);

  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_rd && $past(fuse_rd) && !$stable(fuse_addr)) |-> (fuse_addr == $past(fuse_addr) + 1'b1));

  a_r7_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (fuse_addr == '0 && fuse_rd));

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && !c_sh && !c_ctl) |=> (bus_rdata == '0));
endmodule

bind fuse_shadow_bank fsb_checker #(
  .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .clr_bit(bus_wdata[9]), .bus_rdata(bus_rdata),
  .rd_lock(rd_lock), .wr_lock(wr_lock), .fuse_rd(fuse_rd),
  .fuse_addr(fuse_addr), .busy_o(busy_o), .err_o(err_o)
);

// File: tb/fuse_shadow_bank_test.sv
module fuse_shadow_bank_test;
  localparam int N  = 128;
  localparam int S  = 4;
  localparam logic [31:0] BAD = 32'hBADA_BADA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0, prog_done = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] salt = '0;
  logic [N-1:0] rd_lock, wr_lock;
  logic [31:0] bus_rdata, fuse_rdata;
  logic        fuse_rd, busy_o, err_o;
  logic [6:0]  fuse_addr;

  int total = 0, bad = 0, cyc = 0;

  always #10 clk = ~clk;

  function automatic logic [31:0] fuse_fn(int a, logic [31:0] s);
    return (32'h9E37_79B9 * 32'(a + 1)) ^ s;
  endfunction

  assign fuse_rdata = fuse_fn(int'(fuse_addr), salt);

  fuse_shadow_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rd_lock(rd_lock), .wr_lock(wr_lock), .prog_done(prog_done),
    .fuse_rd(fuse_rd), .fuse_addr(fuse_addr), .fuse_rdata(fuse_rdata),
    .busy_o(busy_o), .err_o(err_o)
  );

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%h expected=%h", tag, what, got, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_sh [N];
  logic        m_busy, m_err, m_boot, o_busy, o_err, m_start, m_hit;
  int          m_idx, m_cnt, m_a, m_w;
  logic [31:0] m_rdata;
  string       m_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 1'b1; m_err = 1'b0; m_boot = 1'b1;
      m_idx = 0; m_cnt = 0; m_rdata = '0; m_tag = "R9";
    end else begin
      o_busy = m_busy; o_err = m_err; m_start = 1'b0;
      m_tag = m_boot ? "R9" : "R7";
      m_a = int'(bus_addr);
      m_w = (m_a - 'h400) / 16;
      m_hit = (m_a >= 'h400) && ((m_a - 'h400) % 16 == 0) && (m_w < N);
      if (bus_rd) begin
        if (m_a == 0 || m_a == 4 || m_a == 8) begin
          m_rdata = (o_busy ? 32'h500 : 32'h0) | (o_err ? 32'h200 : 32'h0);
          m_tag = "R11";
        end else if (m_hit) begin
          if (o_err) begin m_rdata = BAD; m_tag = "R6"; end
          else if (rd_lock[m_w]) begin m_rdata = BAD; m_err = 1'b1; m_tag = "R2"; end
          else begin m_rdata = m_sh[m_w]; m_tag = "R1"; end
        end else begin
          m_rdata = '0; m_tag = "R8";
        end
      end
      if (bus_wr) begin
        if (m_a == 4 && bus_wdata[10]) begin
          if (!o_busy && !o_err) m_start = 1'b1;
          m_tag = o_err ? "R6" : "R5";
        end else if (m_a == 8 && bus_wdata[9]) begin
          m_err = 1'b0; m_tag = "R6";
        end else if (m_hit) begin
          if (o_err) m_tag = "R6";
          else if (o_busy) begin m_err = 1'b1; m_tag = "R3"; end
          else if (wr_lock[m_w]) begin m_err = 1'b1; m_tag = "R4"; end
          else begin m_sh[m_w] = bus_wdata; m_tag = "R1"; end
        end else begin
          m_tag = "R8";
        end
      end
      if (prog_done) begin
        if (!o_busy && !o_err) m_start = 1'b1;
        m_tag = "R10";
      end
      if (o_busy) begin
        if (m_cnt == S - 1) begin
          m_sh[m_idx] = fuse_fn(m_idx, salt);
          m_cnt = 0;
          if (m_idx == N - 1) begin m_busy = 1'b0; m_idx = 0; m_boot = 1'b0; end
          else m_idx++;
        end else begin
          m_cnt++;
        end
      end
      if (m_start) m_busy = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(m_tag, "busy_o", 32'(busy_o), 32'(m_busy));
      chk(m_tag, "err_o", 32'(err_o), 32'(m_err));
      chk(m_tag, "bus_rdata", bus_rdata, m_rdata);
      chk("R7", "fuse_addr", 32'(fuse_addr), 32'(m_idx));
      chk("R7", "fuse_rd", 32'(fuse_rd), 32'(m_busy));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL R7 watchdog: cycles=%0d expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); #2; bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); #2; bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] v);
    @(negedge clk); #2; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk); #2; bus_wr = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); #2; prog_done = 1'b1;
    @(negedge clk); #2; prog_done = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    #2;
  endtask

  function automatic logic [11:0] wa(int i);
    return 12'('h400 + i * 16);
  endfunction

  initial begin
    logic [31:0] d;
    rd_lock = '0; rd_lock[5] = 1'b1; rd_lock[100] = 1'b1;
    wr_lock = '0; wr_lock[7] = 1'b1; wr_lock[127] = 1'b1;
    repeat (3) @(negedge clk);
    #2; rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R9", "busy after reset", 32'(busy_o), 32'd1);
    chk("R9", "err after reset", 32'(err_o), 32'd0);
    rd(12'h000, d); chk("R11", "status during boot copy", d, 32'h500);
    wait_idle();
    for (int i = 0; i < N; i++) begin
      if (!rd_lock[i]) begin
        rd(wa(i), d); chk("R1", "boot shadow word", d, fuse_fn(i, 32'h0));
      end
    end
    rd(wa(5), d); chk("R2", "read-locked data", d, BAD);
    chk("R2", "read-locked err", 32'(err_o), 32'd1);
    rd(wa(6), d); chk("R6", "read while err", d, BAD);
    wr(wa(6), 32'hDEAD_0006);
    wr(12'h004, 32'h400); chk("R6", "copy request while err", 32'(busy_o), 32'd0);
    pulse_done(); chk("R6", "prog_done while err", 32'(busy_o), 32'd0);
    wr(12'h008, 32'h200); chk("R6", "err cleared", 32'(err_o), 32'd0);
    rd(wa(6), d); chk("R6", "write dropped while err", d, fuse_fn(6, 32'h0));
    wr(wa(7), 32'hFFFF_0000); chk("R4", "write-locked err", 32'(err_o), 32'd1);
    rd(12'h008, d); chk("R11", "status with err", d, 32'h200);
    wr(12'h008, 32'h200);
    rd(wa(7), d); chk("R4", "write-locked word kept", d, fuse_fn(7, 32'h0));
    wr(wa(8), 32'h1234_5678);
    rd(wa(8), d); chk("R1", "shadow write readback", d, 32'h1234_5678);
    rd(12'h404, d); chk("R8", "misaligned read", d, 32'h0);
    chk("R8", "misaligned read no err", 32'(err_o), 32'd0);
    rd(12'hC00, d); chk("R8", "past-end read", d, 32'h0);
    rd(12'h010, d); chk("R8", "low unmapped read", d, 32'h0);
    wr(12'h408, 32'hFFFF_FFFF);
    rd(wa(0), d); chk("R8", "misaligned write no effect", d, fuse_fn(0, 32'h0));
    salt = 32'h0F0F_1234;
    pulse_done(); chk("R10", "prog_done starts copy", 32'(busy_o), 32'd1);
    wr(wa(9), 32'hAAAA_5555); chk("R3", "write during copy err", 32'(err_o), 32'd1);
    wr(12'h008, 32'h200); chk("R3", "err clear during copy", 32'(err_o), 32'd0);
    wait_idle();
    rd(wa(8), d); chk("R10", "copy overwrote shadow", d, fuse_fn(8, salt));
    rd(wa(9), d); chk("R3", "write during copy dropped", d, fuse_fn(9, salt));
    salt = 32'h0000_0007;
    wr(12'h004, 32'h400); chk("R5", "set alias starts copy", 32'(busy_o), 32'd1);
    rd(12'h000, d); chk("R11", "status during copy", d, 32'h500);
    wait_idle();
    rd(12'h000, d); chk("R11", "status idle", d, 32'h0);
    rd(wa(127), d); chk("R5", "last word copied", d, fuse_fn(127, salt));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule